// File: doc/BRIEF.md
# Interrupt Status and Mask Aggregator

This block merges many error sources into one active-low interrupt line. Limit checks on voltage and fan channels arrive as per-channel out-of-limit flags, along with a strobe that marks the end of a conversion sweep. Each flagged channel latches a sticky status bit. An active-low thermal input pin latches its own status bit. Every status bit passes through its own mask bit before it can reach the output. Five external request pins skip the status path: each one reaches the output through a per-pin enable and a group enable.

Software sees the block through a small register port with separate read and write strobes. Reading a status byte returns its value and clears it. Reading the mirror copy of the same byte returns the same value and leaves it unchanged. A configuration byte holds a global output enable and a global suppress bit. The suppress bit lets a service routine silence the line while it reconfigures the sources.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, int_n is 1, rdata is 0, both status bytes are 0, both mask bytes are 0xFF, the configuration byte is 0 and the request-mode byte is 0x80.
- R2: On a cycle with conv_done high, every lim_flags bit that is 1 sets its status bit. Channel i maps to status bit i: the low byte (address 3) holds channels 0 to 7 and the high byte (address 4) holds channels 8 to 14. The int_n output reflects the result one cycle later. lim_flags has no effect while conv_done is low.
- R3: A status bit can pull int_n low only while its mask bit is 0. Mask bits for the low status byte are at address 7 and for the high status byte at address 8, with the same bit positions.
- R4: A read of address 3 or 4 returns that status byte on rdata in the cycle after the read strobe and clears the byte. If no other source is active, int_n returns to 1. A later conversion that flags the channel again sets the bit and asserts int_n again. Writes to status addresses have no effect.
- R5: A status bit stays set when a later conversion reports its channel back within limits, and int_n stays low.
- R6: A read of address 5 or 6 returns the low or high status byte and leaves the status unchanged.
- R7: When a status-byte read and a conv_done capture fall in the same cycle, a bit set by the capture stays set. Bits that were only read are cleared.
- R8: Request pins 0 to 2 are active low and pins 3 to 4 are active high. Each pin passes through a two-flop synchroniser. A pin drives int_n low while it is asserted, its enable bit (address 2, bit n for pin n) is 1, and bit 7 of the request-mode byte (address 1) is 0. The pins set no status bit.
- R9: While bit 7 of the request-mode byte is 1, no request pin affects int_n.
- R10: int_n stays 1 while configuration bit 0 (address 0, output enable) is 0 or configuration bit 1 (suppress) is 1.
- R11: While the synchronised therm_n is low, status bit 15 (high byte, bit 7) is set each cycle. That bit is subject to mask bit 7 of address 8 like any other status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| conv_done | input | 1 | Conversion sweep complete strobe |
| lim_flags | input | NUM_LIM | Per-channel out-of-limit flags |
| irq_pins | input | NUM_IRQ | External request pins |
| therm_n | input | 1 | Active-low thermal input pin |
| int_n | output | 1 | Active-low aggregated interrupt |

## Verification
The bench targets the cases where sticky state is easy to get wrong. One is a channel that returns within limits before the read; a design that tracks the live flag would release int_n early. Another is a read that lands in the same cycle as a capture; a design that lets the clear win loses a fresh error. Repeated mirror reads expose a mirror that clears status. Flags driven without the strobe expose capture outside a conversion. The request pins are checked one polarity at a time, along with their per-pin and group enables, and then checked for leaving no status behind. A polarity swap or a latched pin would show up as a stuck or missing interrupt.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
// Package: register addresses and field positions shared by the
// interrupt aggregator modules. Assumes an 8-bit register port.
package irq_agg_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CFG     = 4'h0;
    localparam logic [ADDR_W-1:0] A_MODE    = 4'h1;
    localparam logic [ADDR_W-1:0] A_IRQEN   = 4'h2;
    localparam logic [ADDR_W-1:0] A_STAT_LO = 4'h3;
    localparam logic [ADDR_W-1:0] A_STAT_HI = 4'h4;
    localparam logic [ADDR_W-1:0] A_MIRR_LO = 4'h5;
    localparam logic [ADDR_W-1:0] A_MIRR_HI = 4'h6;
    localparam logic [ADDR_W-1:0] A_MASK_LO = 4'h7;
    localparam logic [ADDR_W-1:0] A_MASK_HI = 4'h8;

    localparam int CFG_OUT_EN_BIT   = 0;
    localparam int CFG_SUPPRESS_BIT = 1;
    localparam int MODE_GRP_DIS_BIT = 7;

    localparam logic [REG_W-1:0] MASK_RST = 8'hFF;
endpackage

// File: rtl/irq_agg_sync.sv
`timescale 1ns/1ps
// Module: multi-stage synchroniser for asynchronous pins.
// Assumes STAGES >= 1; resets every stage to the pins' idle level.
module irq_agg_sync #(
    parameter int WIDTH = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= IDLE;
        else        chain[0] <= d;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each later stage re-samples the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= IDLE;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_agg_status.sv
`timescale 1ns/1ps
// Module: sticky status bits. Channel i sets bit i on a conversion
// strobe, the thermal input sets the top bit every cycle it is active,
// and a byte-wide clear drops bits unless they are set that same cycle.
// Assumes STAT_W is two register bytes and NUM_LIM < STAT_W.
module irq_agg_status #(
    parameter int NUM_LIM = 15,
    parameter int STAT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               conv_done,
    input  logic [NUM_LIM-1:0] lim_flags,
    input  logic               therm_act,
    input  logic               clr_lo,
    input  logic               clr_hi,
    output logic [STAT_W-1:0]  stat_q
);
    import irq_agg_pkg::*;
    localparam int THERM_BIT = STAT_W - 1;

    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;

    genvar i;
    generate
        for (i = 0; i < STAT_W; i++) begin : g_bit
            if (i < NUM_LIM) begin : g_lim
                assign set_vec[i] = conv_done & lim_flags[i];
            end else if (i == THERM_BIT) begin : g_therm
                assign set_vec[i] = therm_act;
            end else begin : g_none
                assign set_vec[i] = 1'b0;
            end
            if (i < REG_W) begin : g_lo
                assign clr_vec[i] = clr_lo;
            end else begin : g_hi
                assign clr_vec[i] = clr_hi;
            end
        end
    endgenerate

    // Sticky update: a new set wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/irq_agg_irq.sv
`timescale 1ns/1ps
// Module: request pin gating. Applies per-pin polarity, per-pin
// enables and the group disable. Assumes pins are already synchronised.
module irq_agg_irq #(
    parameter int NUM_IRQ = 5,
    parameter logic [NUM_IRQ-1:0] HIGH_MASK = 5'b11000
) (
    input  logic [NUM_IRQ-1:0] pins_sync,
    input  logic [NUM_IRQ-1:0] pin_en,
    input  logic               grp_dis,
    output logic               irq_hit
);
    logic [NUM_IRQ-1:0] active;

    genvar p;
    generate
        for (p = 0; p < NUM_IRQ; p++) begin : g_pin
            if (HIGH_MASK[p]) begin : g_high
                assign active[p] = pins_sync[p];
            end else begin : g_low
                assign active[p] = ~pins_sync[p];
            end
        end
    endgenerate

    // Any enabled, asserted pin raises the request unless the group is off.
    always_comb begin
        irq_hit = !grp_dis && |(active & pin_en);
    end
endmodule

// File: rtl/irq_agg_regs.sv
`timescale 1ns/1ps
// Module: control registers, read mux and clear-on-read pulses.
// Assumes one access per cycle; rdata is registered on rd_en.
module irq_agg_regs #(
    parameter int NUM_IRQ = 5,
    parameter int STAT_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          rd_en,
    input  logic [irq_agg_pkg::ADDR_W-1:0] addr,
    input  logic [irq_agg_pkg::REG_W-1:0]  wdata,
    input  logic [STAT_W-1:0]             stat_q,
    output logic [irq_agg_pkg::REG_W-1:0]  rdata,
    output logic                          out_en,
    output logic                          int_clr,
    output logic                          grp_dis,
    output logic [NUM_IRQ-1:0]            pin_en,
    output logic [STAT_W-1:0]             mask_q,
    output logic                          clr_lo,
    output logic                          clr_hi
);
    import irq_agg_pkg::*;

    logic [REG_W-1:0] rd_mux;

    // Control register writes; status and mirror addresses ignore writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_en  <= 1'b0;
            int_clr <= 1'b0;
            grp_dis <= 1'b1;
            pin_en  <= '0;
            mask_q  <= {MASK_RST, MASK_RST};
        end else if (wr_en) begin
            case (addr)
                A_CFG: begin
                    out_en  <= wdata[CFG_OUT_EN_BIT];
                    int_clr <= wdata[CFG_SUPPRESS_BIT];
                end
                A_MODE:    grp_dis <= wdata[MODE_GRP_DIS_BIT];
                A_IRQEN:   pin_en <= wdata[NUM_IRQ-1:0];
                A_MASK_LO: mask_q[REG_W-1:0] <= wdata;
                A_MASK_HI: mask_q[STAT_W-1:REG_W] <= wdata;
                default: ;
            endcase
        end
    end

    // Read data selection.
    always_comb begin
        rd_mux = '0;
        case (addr)
            A_CFG: begin
                rd_mux[CFG_OUT_EN_BIT]   = out_en;
                rd_mux[CFG_SUPPRESS_BIT] = int_clr;
            end
            A_MODE:    rd_mux[MODE_GRP_DIS_BIT] = grp_dis;
            A_IRQEN:   rd_mux[NUM_IRQ-1:0] = pin_en;
            A_STAT_LO,
            A_MIRR_LO: rd_mux = stat_q[REG_W-1:0];
            A_STAT_HI,
            A_MIRR_HI: rd_mux = stat_q[STAT_W-1:REG_W];
            A_MASK_LO: rd_mux = mask_q[REG_W-1:0];
            A_MASK_HI: rd_mux = mask_q[STAT_W-1:REG_W];
            default:   rd_mux = '0;
        endcase
    end

    // Clear pulses go only to the clearing status addresses, not the mirrors.
    always_comb begin
        clr_lo = rd_en && (addr == A_STAT_LO);
        clr_hi = rd_en && (addr == A_STAT_HI);
    end

    // Register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end
endmodule

// File: rtl/irq_aggregator.sv
`timescale 1ns/1ps
// Module: interrupt aggregator top. Merges sticky limit and thermal
// status (through masks) with gated request pins into one registered
// active-low interrupt, under a global enable and suppress.
// Assumes asynchronous pins; everything else is synchronous to clk.
module irq_aggregator #(
    parameter int NUM_LIM = 15,
    parameter int NUM_IRQ = 5,
    parameter logic [NUM_IRQ-1:0] IRQ_HIGH_MASK = 5'b11000,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [3:0]         addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    input  logic               conv_done,
    input  logic [NUM_LIM-1:0] lim_flags,
    input  logic [NUM_IRQ-1:0] irq_pins,
    input  logic               therm_n,
    output logic               int_n
);
    import irq_agg_pkg::*;
    localparam int STAT_W = 2 * REG_W;

    logic [NUM_IRQ-1:0] pins_sync;
    logic               therm_sync;
    logic [STAT_W-1:0]  stat_q;
    logic [STAT_W-1:0]  mask_q;
    logic [NUM_IRQ-1:0] pin_en;
    logic               out_en;
    logic               int_clr;
    logic               grp_dis;
    logic               clr_lo;
    logic               clr_hi;
    logic               irq_hit;
    logic               src_any;

    irq_agg_sync #(.WIDTH(NUM_IRQ), .STAGES(SYNC_STAGES), .IDLE(~IRQ_HIGH_MASK)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(irq_pins), .q(pins_sync)
    );

    irq_agg_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .IDLE(1'b1)) u_therm_sync (
        .clk(clk), .rst_n(rst_n), .d(therm_n), .q(therm_sync)
    );

    irq_agg_status #(.NUM_LIM(NUM_LIM), .STAT_W(STAT_W)) u_status (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .lim_flags(lim_flags),
        .therm_act(!therm_sync), .clr_lo(clr_lo), .clr_hi(clr_hi), .stat_q(stat_q)
    );

    irq_agg_irq #(.NUM_IRQ(NUM_IRQ), .HIGH_MASK(IRQ_HIGH_MASK)) u_irq (
        .pins_sync(pins_sync), .pin_en(pin_en), .grp_dis(grp_dis), .irq_hit(irq_hit)
    );

    irq_agg_regs #(.NUM_IRQ(NUM_IRQ), .STAT_W(STAT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .stat_q(stat_q), .rdata(rdata), .out_en(out_en),
        .int_clr(int_clr), .grp_dis(grp_dis), .pin_en(pin_en), .mask_q(mask_q),
        .clr_lo(clr_lo), .clr_hi(clr_hi)
    );

    // Any unmasked status bit or gated request pin is a live source.
    always_comb begin
        src_any = (|(stat_q & ~mask_q)) | irq_hit;
    end

    // Register the output under the global enable and suppress.
    always_ff @(posedge clk) begin
        if (!rst_n) int_n <= 1'b1;
        else        int_n <= !(out_en && !int_clr && src_any);
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
`timescale 1ns/1ps
// Module: assertion checker bound to irq_aggregator.
module irq_aggregator_chk #(
    parameter int NUM_LIM = 15,
    parameter int STAT_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               conv_done,
    input logic [NUM_LIM-1:0] lim_flags,
    input logic               rd_en,
    input logic [3:0]         addr,
    input logic               int_n,
    input logic [STAT_W-1:0]  stat_q,
    input logic [STAT_W-1:0]  mask_q,
    input logic               irq_hit,
    input logic               out_en,
    input logic               int_clr
);
    import irq_agg_pkg::*;

    assert_reset_quiet_R1: assert property (@(posedge clk) !rst_n |=> int_n);

    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && lim_flags[0] |=> stat_q[0]);

    assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~mask_q) == '0) && !irq_hit |=> int_n);

    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && (addr == A_STAT_LO || addr == A_STAT_HI))
        |=> (($past(stat_q) & ~stat_q) == '0));

    assert_mirror_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (addr == A_MIRR_LO || addr == A_MIRR_HI)
        |=> (($past(stat_q) & ~stat_q) == '0));

    assert_new_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && addr == A_STAT_LO && conv_done && lim_flags[0] |=> stat_q[0]);

    assert_suppress_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int_clr |=> int_n);

    assert_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> int_n);
endmodule

bind irq_aggregator irq_aggregator_chk #(.NUM_LIM(NUM_LIM), .STAT_W(STAT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .lim_flags(lim_flags),
    .rd_en(rd_en), .addr(addr), .int_n(int_n), .stat_q(stat_q), .mask_q(mask_q),
    .irq_hit(irq_hit), .out_en(out_en), .int_clr(int_clr)
);

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected items, a monitor pops
// and compares them against the ports.
module irq_aggregator_bench;
    localparam int NUM_LIM = 15;
    localparam int NUM_IRQ = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic               rd_en = 1'b0;
    logic [3:0]         addr = '0;
    logic [7:0]         wdata = '0;
    logic [7:0]         rdata;
    logic               conv_done = 1'b0;
    logic [NUM_LIM-1:0] lim_flags = '0;
    logic [NUM_IRQ-1:0] irq_pins = 5'b00111;
    logic               therm_n = 1'b1;
    logic               int_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit         is_int;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t exp_q[$];
    event sample_ev;

    always #10 clk = ~clk;

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .conv_done(conv_done), .lim_flags(lim_flags),
        .irq_pins(irq_pins), .therm_n(therm_n), .int_n(int_n)
    );

    // Monitor: pop each expected item and compare it with the port.
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = exp_q.pop_front();
                act = it.is_int ? {7'b0, int_n} : rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %0h expected %0h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic push(input bit is_int, input logic [7:0] e, input string req);
        item_t it;
        it.is_int = is_int; it.exp = e; it.req = req;
        exp_q.push_back(it);
        -> sample_ev;
        wait (exp_q.size() == 0);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [7:0] e, input string req);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0;
        push(1'b0, e, req);
    endtask

    task automatic convert(input logic [NUM_LIM-1:0] f);
        @(negedge clk); conv_done = 1'b1; lim_flags = f;
        @(negedge clk); conv_done = 1'b0; lim_flags = '0;
    endtask

    task automatic check_int(input logic e, input string req);
        settle();
        push(1'b1, {7'b0, e}, req);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        push(1'b1, 8'h01, "R1 int_n in reset");
        rst_n = 1'b1;
        check_int(1'b1, "R1 int_n after reset");
        bus_read(4'h7, 8'hFF, "R1 mask lo reset");
        bus_read(4'h8, 8'hFF, "R1 mask hi reset");
        bus_read(4'h1, 8'h80, "R1 mode reset");
        bus_read(4'h0, 8'h00, "R1 cfg reset");
        bus_read(4'h3, 8'h00, "R1 status lo reset");

        bus_write(4'h0, 8'h01);
        bus_write(4'h7, 8'h00);
        bus_write(4'h8, 8'h00);
        check_int(1'b1, "R10 enabled, no source");

        // R2: flags without the strobe are ignored.
        @(negedge clk); lim_flags = 15'h0001;
        repeat (3) @(negedge clk); lim_flags = '0;
        check_int(1'b1, "R2 flags without strobe");
        bus_read(4'h5, 8'h00, "R2 no capture without strobe");

        convert(15'h0005);
        check_int(1'b0, "R2 capture asserts");
        bus_read(4'h5, 8'h05, "R6 mirror value");
        bus_read(4'h5, 8'h05, "R6 mirror not cleared");
        convert(15'h0000);
        check_int(1'b0, "R5 back in limits stays asserted");
        bus_read(4'h5, 8'h05, "R5 status sticky");
        bus_read(4'h3, 8'h05, "R4 status read value");
        check_int(1'b1, "R4 read releases int");
        bus_read(4'h5, 8'h00, "R4 read cleared");
        convert(15'h0001);
        check_int(1'b0, "R4 re-fires on next conversion");
        bus_read(4'h3, 8'h01, "R4 second read");
        bus_write(4'h3, 8'hFF);
        bus_read(4'h5, 8'h00, "R4 write to status ignored");
        check_int(1'b1, "R4 write to status no int");

        // R3: masking.
        bus_write(4'h7, 8'h02);
        convert(15'h0002);
        check_int(1'b1, "R3 masked bit quiet");
        bus_read(4'h5, 8'h02, "R3 masked bit still latched");
        bus_write(4'h7, 8'h00);
        check_int(1'b0, "R3 unmask asserts");
        bus_read(4'h3, 8'h02, "R3 clear");
        check_int(1'b1, "R3 clear releases");

        // High byte channel.
        convert(15'h0200);
        check_int(1'b0, "R2 high byte channel asserts");
        bus_read(4'h6, 8'h02, "R2 high byte mirror");
        bus_read(4'h3, 8'h00, "R2 low byte empty");
        bus_read(4'h4, 8'h02, "R2 high byte read");
        check_int(1'b1, "R4 high clear releases");

        // R7: clear and capture in the same cycle.
        convert(15'h0001);
        @(negedge clk); rd_en = 1'b1; addr = 4'h3; conv_done = 1'b1; lim_flags = 15'h0011;
        @(negedge clk); rd_en = 1'b0; conv_done = 1'b0; lim_flags = '0;
        push(1'b0, 8'h01, "R7 read returns old value");
        bus_read(4'h5, 8'h11, "R7 new capture kept");
        check_int(1'b0, "R7 int stays asserted");
        @(negedge clk); rd_en = 1'b1; addr = 4'h3; conv_done = 1'b1; lim_flags = 15'h0010;
        @(negedge clk); rd_en = 1'b0; conv_done = 1'b0; lim_flags = '0;
        push(1'b0, 8'h11, "R7 second collide read");
        bus_read(4'h5, 8'h10, "R7 read-only bit cleared");
        bus_read(4'h3, 8'h10, "R7 final clear");
        check_int(1'b1, "R7 released");

        // R11: thermal pin.
        @(negedge clk); therm_n = 1'b0;
        repeat (4) @(negedge clk); therm_n = 1'b1;
        check_int(1'b0, "R11 thermal asserts");
        bus_read(4'h6, 8'h80, "R11 thermal status bit");
        bus_write(4'h8, 8'h80);
        check_int(1'b1, "R11 thermal masked");
        bus_write(4'h8, 8'h00);
        bus_read(4'h4, 8'h80, "R11 thermal read clear");
        check_int(1'b1, "R11 thermal released");

        // R8/R9: request pins.
        bus_write(4'h2, 8'h1F);
        bus_write(4'h1, 8'h00);
        check_int(1'b1, "R8 idle pins quiet");
        @(negedge clk); irq_pins[1] = 1'b0;
        check_int(1'b0, "R8 active-low pin asserts");
        bus_read(4'h5, 8'h00, "R8 no status lo from pin");
        bus_read(4'h6, 8'h00, "R8 no status hi from pin");
        @(negedge clk); irq_pins[1] = 1'b1;
        check_int(1'b1, "R8 pin release is not sticky");
        @(negedge clk); irq_pins[3] = 1'b1;
        check_int(1'b0, "R8 active-high pin asserts");
        bus_write(4'h2, 8'h17);
        check_int(1'b1, "R8 pin enable cleared");
        bus_write(4'h2, 8'h1F);
        check_int(1'b0, "R8 pin enable restored");
        bus_write(4'h1, 8'h80);
        check_int(1'b1, "R9 group disabled");
        @(negedge clk); irq_pins[0] = 1'b0;
        check_int(1'b1, "R9 group disabled second pin");
        @(negedge clk); irq_pins[0] = 1'b1;
        bus_write(4'h1, 8'h00);
        check_int(1'b0, "R9 group re-enabled");

        // R10: suppress and output enable.
        bus_write(4'h0, 8'h03);
        check_int(1'b1, "R10 suppress");
        bus_read(4'h0, 8'h03, "R10 cfg readback");
        bus_write(4'h0, 8'h01);
        check_int(1'b0, "R10 suppress released");
        bus_write(4'h0, 8'h00);
        check_int(1'b1, "R10 output disabled");
        @(negedge clk); irq_pins[3] = 1'b0;
        bus_write(4'h0, 8'h01);
        check_int(1'b1, "R8 pin deasserted quiet");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule